// File: doc/BRIEF.md
# Dual-Supply Priority Selector Controller

This controller decides which of two supply rails feeds each of two load outputs, A and B, and sequences the four power switches that make those connections. Comparator flags arrive as plain synchronous inputs. Each supply has an in-window flag, and supply 1 also has an over-threshold flag. Each output has a flag that is set while its voltage still sits above the rail it is about to join. A single-cycle timebase tick, nominally one microsecond, paces every timed action.

Supply 1 always wins when it is in its window. Output A falls back to supply 2 whenever supply 1 is out of its window and supply 2 is in. Output B falls back to supply 2 only when supply 1 is over-threshold and supply 2 is in window. Output B also needs an external gate from the mode logic. Each output runs its own state machine. A change of rail first opens both switches. The machine then waits for the output to discharge below the new rail, and then ramps the switch through four soft-start stages before holding it fully on. A force-open input, driven for example by thermal shutdown, drops everything at once.

Top module: `supsel_ctrl`

## Requirements
- R1: Output A targets supply 1 when `sup1_ok` is 1, otherwise supply 2 when `sup2_ok` is 1, otherwise nothing. The target depends only on the present flags, whatever order the supplies came up in.
- R2: Output B targets supply 1 when `outb_gate` and `sup1_ok` are both 1. It targets supply 2 only when `outb_gate`, `sup1_over` and `sup2_ok` are all 1 and `sup1_ok` is 0. In every other case output B targets nothing.
- R3: When an output sits on supply 2 and supply 1 returns to its window, the supply 2 switch opens on the next clock edge and the output later settles on supply 1.
- R4: With no usable target, both switches of that output are open and their stage codes read 0.
- R5: After entering a transition, a switch stays open with stage code 0 while that output's above-rail flag is 1. Ramping begins on the first tick edge at which the flag reads 0.
- R6: Stage codes are 3 bits wide. Code 0 means the switch is open, and codes 1 to 4 are the ramp steps. Each step lasts `STEP_TICKS` ticks. After step 4 the switch is fully on and keeps code 4. Nothing advances on an edge without a tick.
- R7: The two switches of one output are never enabled together. A switch closes only after a clock edge on which both switches of that output were open. A move from open to a transition happens only on a tick.
- R8: While `force_off` is 1, all four switches are open and all stage codes are 0 from the next edge on. After release, the normal sequence restarts.
- R9: During and right after reset, all switch enables and stage codes are 0.
- The `sw_en` bits are ordered A-from-supply-1, A-from-supply-2, B-from-supply-1, B-from-supply-2, bit 0 first. The stage code of switch i sits in `sw_stage[3*i+2:3*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase strobe |
| sup1_ok | input | 1 | Supply 1 inside its window |
| sup1_over | input | 1 | Supply 1 above the upper threshold |
| sup2_ok | input | 1 | Supply 2 inside its window |
| outb_gate | input | 1 | Mode-logic enable for output B |
| outa_above | input | 1 | Output A still above its target rail |
| outb_above | input | 1 | Output B still above its target rail |
| force_off | input | 1 | Force all switches open |
| sw_en | output | 4 | Switch enables: A1, A2, B1, B2 (bit 0 first) |
| sw_stage | output | 12 | Soft-start code per switch, 3 bits each |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around the sampling edge. They also assume that `tick` is a strobe, and that the above-rail flags refer to whichever rail the output is heading for. The bench changes inputs only on falling edges and samples just after rising edges. It runs the fast-ramp checks with `tick` held high, and holds `tick` low where the check is that nothing advances. It never asserts the supply flags in combinations the comparators cannot produce, such as in-window and over-threshold together.

// File: rtl/supsel_pkg.sv
package supsel_pkg;
  typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_S1 = 2'd1, TGT_S2 = 2'd2} tgt_e;
  typedef enum logic [2:0] {
    ST_OPEN = 3'd0, ST_TR1 = 3'd1, ST_ON1 = 3'd2, ST_TR2 = 3'd3, ST_ON2 = 3'd4
  } st_e;
  localparam int STAGE_W  = 3;
  localparam int LAST_STG = 4;
endpackage

// File: rtl/supsel_target.sv
module supsel_target
  import supsel_pkg::*;
#(
  parameter bit STRICT_FALLBACK = 1'b0
) (
  input  logic s1_ok,
  input  logic s1_over,
  input  logic s2_ok,
  input  logic gate,
  output tgt_e tgt
);
  logic fallback_ok;

  generate
    if (STRICT_FALLBACK) begin : g_strict
      assign fallback_ok = s1_over && s2_ok;
    end else begin : g_loose
      assign fallback_ok = s2_ok;
    end
  endgenerate

  always_comb begin
    tgt = TGT_NONE;
    if (gate) begin
      if (s1_ok)            tgt = TGT_S1;
      else if (fallback_ok) tgt = TGT_S2;
    end
  end
endmodule

// File: rtl/supsel_out_fsm.sv
module supsel_out_fsm
  import supsel_pkg::*;
#(
  parameter int STEP_TICKS = 250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               force_off,
  input  tgt_e               tgt,
  input  logic               above,
  output logic               en1,
  output logic               en2,
  output logic [STAGE_W-1:0] stg1,
  output logic [STAGE_W-1:0] stg2
);
  localparam int CNT_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_TICKS - 1);

  st_e                st;
  logic [STAGE_W-1:0] stg;
  logic [CNT_W-1:0]   cnt;
  tgt_e               mine;

  always_comb begin
    case (st)
      ST_TR1, ST_ON1: mine = TGT_S1;
      ST_TR2, ST_ON2: mine = TGT_S2;
      default:        mine = TGT_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || force_off) begin
      st  <= ST_OPEN;
      stg <= '0;
      cnt <= '0;
    end else begin
      case (st)
        ST_OPEN: begin
          stg <= '0;
          cnt <= '0;
          if (tick) begin
            if (tgt == TGT_S1)      st <= ST_TR1;
            else if (tgt == TGT_S2) st <= ST_TR2;
          end
        end
        ST_TR1, ST_TR2: begin
          if (tgt != mine) begin
            st  <= ST_OPEN;
            stg <= '0;
            cnt <= '0;
          end else if (stg == '0) begin
            if (tick && !above) begin
              stg <= STAGE_W'(1);
              cnt <= '0;
            end
          end else if (tick) begin
            if (cnt == CNT_LAST) begin
              cnt <= '0;
              if (stg == STAGE_W'(LAST_STG)) st <= (st == ST_TR1) ? ST_ON1 : ST_ON2;
              else                           stg <= stg + STAGE_W'(1);
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        default: begin
          if (tgt != mine) begin
            st  <= ST_OPEN;
            stg <= '0;
            cnt <= '0;
          end
        end
      endcase
    end
  end

  assign en1  = (st == ST_ON1) || ((st == ST_TR1) && (stg != '0));
  assign en2  = (st == ST_ON2) || ((st == ST_TR2) && (stg != '0));
  assign stg1 = en1 ? stg : '0;
  assign stg2 = en2 ? stg : '0;

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(en1 && en2));
  a_r7_open_before_close1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en1) |-> $past(!en1 && !en2));
  a_r7_open_before_close2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en2) |-> $past(!en1 && !en2));
  a_r5_discharged_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en1) || $rose(en2)) |-> $past(!above && tick));
  a_r8_force_opens: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_off) |-> (!en1 && !en2 && stg1 == '0 && stg2 == '0));
  a_r6_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en1 && $past(en1) && stg1 != $past(stg1)) |-> (stg1 == $past(stg1) + STAGE_W'(1) && $past(tick)));
  a_r6_stage_range: assert property (@(posedge clk) disable iff (!rst_n)
    stg1 <= STAGE_W'(LAST_STG) && stg2 <= STAGE_W'(LAST_STG));
endmodule

// File: rtl/supsel_ctrl.sv
module supsel_ctrl
  import supsel_pkg::*;
#(
  parameter int STEP_TICKS = 250,
  parameter int N_OUT      = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       sup1_ok,
  input  logic                       sup1_over,
  input  logic                       sup2_ok,
  input  logic                       outb_gate,
  input  logic                       outa_above,
  input  logic                       outb_above,
  input  logic                       force_off,
  output logic [2*N_OUT-1:0]         sw_en,
  output logic [2*N_OUT*STAGE_W-1:0] sw_stage
);
  logic [N_OUT-1:0] gate_v;
  logic [N_OUT-1:0] above_v;

  assign gate_v  = {outb_gate, 1'b1};
  assign above_v = {outb_above, outa_above};

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    tgt_e tgt;

    supsel_target #(.STRICT_FALLBACK(i != 0)) u_tgt (
      .s1_ok   (sup1_ok),
      .s1_over (sup1_over),
      .s2_ok   (sup2_ok),
      .gate    (gate_v[i]),
      .tgt     (tgt)
    );

    supsel_out_fsm #(.STEP_TICKS(STEP_TICKS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .force_off (force_off),
      .tgt       (tgt),
      .above     (above_v[i]),
      .en1       (sw_en[2*i]),
      .en2       (sw_en[2*i+1]),
      .stg1      (sw_stage[(2*i)*STAGE_W +: STAGE_W]),
      .stg2      (sw_stage[(2*i+1)*STAGE_W +: STAGE_W])
    );
  end

  a_r3_s1_preempts_s2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sup1_ok) |-> (!sw_en[1] && !sw_en[3]));
  a_r2_b_needs_over: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sup1_over || !outb_gate) |-> !sw_en[3]);
  a_r4_none_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sup1_ok && !sup2_ok) |-> (sw_en == '0));
endmodule

// File: tb/supsel_ctrl_tb_top.sv
module supsel_ctrl_tb_top;
  localparam int STEP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        sup1_ok = 1'b0, sup1_over = 1'b0, sup2_ok = 1'b0;
  logic        outb_gate = 1'b0, outa_above = 1'b0, outb_above = 1'b0;
  logic        force_off = 1'b0;
  logic [3:0]  sw_en;
  logic [11:0] sw_stage;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  supsel_ctrl #(.STEP_TICKS(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .sup1_ok(sup1_ok), .sup1_over(sup1_over), .sup2_ok(sup2_ok),
    .outb_gate(outb_gate), .outa_above(outa_above), .outb_above(outb_above),
    .force_off(force_off), .sw_en(sw_en), .sw_stage(sw_stage)
  );

  // vector: {sup1_ok, sup1_over, sup2_ok, outb_gate, expected sw_en[3:0]}
  localparam logic [7:0] VEC [8] = '{
    8'b1001_0101,  // R1 R2 supply 1 feeds both
    8'b0011_0010,  // R1 R2 supply 1 absent: A falls back, B open
    8'b0111_1010,  // R2 supply 1 over: both on supply 2
    8'b1011_0101,  // R3 supply 1 back: both return
    8'b1010_0001,  // R2 gate low drops B
    8'b0001_0000,  // R4 nothing valid
    8'b0101_0000,  // R4 over, supply 2 absent
    8'b0110_0010   // R2 over but gate low
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] stg_for(input logic [3:0] en);
    logic [11:0] s = '0;
    for (int i = 0; i < 4; i++) if (en[i]) s[3*i +: 3] = 3'd4;
    return s;
  endfunction

  initial begin
    @(negedge clk);
    cyc(2);
    chk("R9 reset en", sw_en, 0);
    chk("R9 reset stage", sw_stage, 0);
    @(negedge clk) rst_n = 1'b1;
    cyc(1);
    chk("R9 after reset", sw_en, 0);

    // R6: no tick, no movement
    @(negedge clk) begin tick = 1'b0; sup1_ok = 1'b1; end
    cyc(5);
    chk("R6 no tick holds open", sw_en, 0);

    // R5: discharge wait
    @(negedge clk) begin tick = 1'b1; outa_above = 1'b1; end
    cyc(6);
    chk("R5 waits while above", sw_en[0], 0);
    chk("R5 stage 0 while above", sw_stage[2:0], 0);
    @(negedge clk) outa_above = 1'b0;
    cyc(1);
    chk("R6 first stage", sw_stage[2:0], 1);
    chk("R6 switch closed at stage 1", sw_en[0], 1);
    cyc(2);
    chk("R6 second stage", sw_stage[2:0], 2);
    cyc(4);
    chk("R6 fourth stage", sw_stage[2:0], 4);
    cyc(6);
    chk("R6 fully on keeps 4", sw_stage[2:0], 4);

    // R7: break before make on switch-over
    @(negedge clk) begin sup1_ok = 1'b0; sup2_ok = 1'b1; end
    cyc(1);
    chk("R7 both A switches open", sw_en[1:0], 0);
    cyc(20);
    chk("R1 A settles on supply 2", sw_en[1:0], 2'b10);

    // R8: force open
    @(negedge clk) force_off = 1'b1;
    cyc(1);
    chk("R8 force opens", sw_en, 0);
    cyc(5);
    chk("R8 stages cleared", sw_stage, 0);
    @(negedge clk) force_off = 1'b0;
    cyc(20);
    chk("R8 restart after release", sw_en, 4'b0010);

    for (int v = 0; v < 8; v++) begin
      @(negedge clk) begin
        sup1_ok = VEC[v][7]; sup1_over = VEC[v][6];
        sup2_ok = VEC[v][5]; outb_gate = VEC[v][4];
      end
      cyc(25);
      chk($sformatf("R1/R2/R3/R4 vector %0d en", v), sw_en, VEC[v][3:0]);
      chk($sformatf("R6 vector %0d stage", v), sw_stage, stg_for(VEC[v][3:0]));
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule